// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire link: an active-low select, a data line and a serial clock. Each word holds a 4-bit command in its upper nibble and a 12-bit payload below it. The block turns accepted words into a held 12-bit code for the converter core and a 2-bit power state. The power state chooses normal drive, a floating output, or one of two pull-down paths to ground.

The three link inputs are asynchronous to the system clock, so the block resynchronises them first. Bits are taken on falling serial-clock edges while select is low. A word is acted on only at the rising edge of select, and only if exactly 16 bits arrived. A single-cycle strobe in the system clock domain marks every accepted command. One command sets the code. Another picks the power state, and the code is kept while powered down, so waking up restores the last value.

Top module: `sdac_cmd_if`

## Requirements
- R1: After reset `dac_code` is 0, `pwr_mode` is 00 (normal) and `upd_stb` is low.
- R2: A word whose upper four bits (bits 15:12, sent first) are 0000 loads bits 11:0 into `dac_code`. Bits go MSB first.
- R3: A word with upper bits 1111 sets `pwr_mode` to bits 1:0 (00 normal, 01 floating, 10 1 kΩ pull-down, 11 100 kΩ pull-down). Bits 11:2 are ignored and `dac_code` is unchanged.
- R4: A wake-up word (1111 with bits 1:0 = 00) brings back the code held before power-down. The code is not cleared.
- R5: A load word received in any power-down state updates `dac_code` and returns `pwr_mode` to 00, both in the same cycle.
- R6: Words with any other command value change neither `dac_code` nor `pwr_mode` and give no strobe.
- R7: A frame of fewer or more than 16 falling serial-clock edges between select low and select high is discarded with no effect.
- R8: `upd_stb` is high for exactly one system-clock cycle per accepted word. That is the first cycle in which the new outputs are visible. It is low at all other times.
- R9: Serial-clock edges while select is high shift nothing and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Held code driven to the converter core |
| pwr_mode | output | 2 | Power state: 00 normal, 01 floating, 10 1 kΩ, 11 100 kΩ |
| upd_stb | output | 1 | One-cycle pulse when an accepted word takes effect |

## Verification
The two functions that meet in one cycle are the code write and the exit from power-down. A load word arriving in a pull-down state must change `dac_code` and clear `pwr_mode` on the same strobe. The bench provokes this by parking the block in the 1 kΩ state and then sending a load. The scoreboard item for that word carries both the new code and mode 00, and the monitor compares both in the strobe cycle. A bound property also requires a code change on a strobe to come with normal mode.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'b00,
      PM_FLOAT  = 2'b01,
      PM_R1K    = 2'b10,
      PM_R100K  = 2'b11
   } pmode_t;

   localparam int CMD_W_DEF  = 4;
   localparam int DATA_W_DEF = 12;
   localparam int MODE_W     = 2;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_s,
   input  logic                  sclk_s,
   input  logic                  din_s,
   output logic [FRAME_BITS-1:0] frame_word,
   output logic                  frame_ok
);

   localparam int CNT_W   = $clog2(FRAME_BITS + 2);
   localparam int CNT_SAT = FRAME_BITS + 1;

   logic             prev_cs;
   logic             prev_sclk;
   logic [CNT_W-1:0] bit_cnt;
   logic             sclk_fall;
   logic             cs_rise;

   assign sclk_fall = prev_sclk & ~sclk_s & ~cs_s;
   assign cs_rise   = ~prev_cs & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs    <= 1'b1;
         prev_sclk  <= 1'b0;
         bit_cnt    <= '0;
         frame_word <= '0;
      end else begin
         prev_cs   <= cs_s;
         prev_sclk <= sclk_s;
         if (sclk_fall) begin
            frame_word <= {frame_word[FRAME_BITS-2:0], din_s};
            if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
         end else if (cs_s && prev_cs) begin
            bit_cnt <= '0;
         end
      end
   end

   assign frame_ok = cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));

endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
   import sdac_pkg::*;
#(
   parameter int                CMD_W    = CMD_W_DEF,
   parameter int                DATA_W   = DATA_W_DEF,
   parameter logic [CMD_W-1:0]  CMD_LOAD = '0,
   parameter logic [CMD_W-1:0]  CMD_PWR  = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_ok,
   input  logic [CMD_W+DATA_W-1:0] frame_word,
   output logic [DATA_W-1:0]       code,
   output pmode_t                  mode,
   output logic                    upd
);

   localparam int FB = CMD_W + DATA_W;

   logic [CMD_W-1:0]  cmd;
   logic [DATA_W-1:0] payload;
   pmode_t            sel;

   assign cmd     = frame_word[FB-1 -: CMD_W];
   assign payload = frame_word[DATA_W-1:0];
   assign sel     = pmode_t'(payload[MODE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         mode <= PM_NORMAL;
         upd  <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (frame_ok) begin
            if (cmd == CMD_LOAD) begin
               code <= payload;
               mode <= PM_NORMAL;
               upd  <= 1'b1;
            end else if (cmd == CMD_PWR) begin
               mode <= sel;
               upd  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
   import sdac_pkg::*;
#(
   parameter int CMD_W       = CMD_W_DEF,
   parameter int DATA_W      = DATA_W_DEF,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [DATA_W-1:0] dac_code,
   output logic [1:0]        pwr_mode,
   output logic              upd_stb
);

   localparam int FRAME_BITS = CMD_W + DATA_W;

   generate
      if (DATA_W < MODE_W) begin : g_bad_data
         $error("DATA_W must hold the mode select field");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("CMD_W must be at least 2");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic [2:0]            sync_q;
   logic                  frame_ok;
   logic [FRAME_BITS-1:0] frame_word;
   pmode_t                mode_q;

   sdac_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdin}),
      .q     (sync_q)
   );

   sdac_shifter #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (sync_q[2]),
      .sclk_s     (sync_q[1]),
      .din_s      (sync_q[0]),
      .frame_word (frame_word),
      .frame_ok   (frame_ok)
   );

   sdac_decode #(
      .CMD_W  (CMD_W),
      .DATA_W (DATA_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_ok   (frame_ok),
      .frame_word (frame_word),
      .code       (dac_code),
      .mode       (mode_q),
      .upd        (upd_stb)
   );

   assign pwr_mode = mode_q;

endmodule

// File: rtl/sdac_cmd_if_chk.sv
module sdac_cmd_if_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] dac_code,
   input logic [1:0]        pwr_mode,
   input logic              upd_stb
);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb);

   a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |-> ($stable(dac_code) && $stable(pwr_mode)));

   a_r3_powerdown_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && pwr_mode != 2'b00) |-> $stable(dac_code));

   a_r5_load_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !$stable(dac_code)) |-> (pwr_mode == 2'b00));

endmodule

bind sdac_cmd_if sdac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dac_code (dac_code),
   .pwr_mode (pwr_mode),
   .upd_stb  (upd_stb)
);

// File: tb/sdac_cmd_if_tb.sv
`timescale 1ns/1ps
module sdac_cmd_if_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdin = 1'b0;
   logic [11:0] dac_code;
   logic [1:0]  pwr_mode;
   logic        upd_stb;

   int checks = 0;
   int failures = 0;

   logic [11:0] exp_code = '0;
   logic [1:0]  exp_mode = '0;
   logic [13:0] sb_q [$];
   logic        prev_stb = 1'b0;

   always #5 clk = ~clk;

   sdac_cmd_if u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdin     (sdin),
      .dac_code (dac_code),
      .pwr_mode (pwr_mode),
      .upd_stb  (upd_stb)
   );

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items on each strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (upd_stb && prev_stb) chk(1'b0, "R8 strobe longer than one cycle", 16'd2, 16'd1);
         if (upd_stb && !prev_stb) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R6/R7 strobe without accepted word", {2'b0, pwr_mode, dac_code}, 16'h0);
            end else begin
               logic [13:0] it;
               it = sb_q.pop_front();
               chk({pwr_mode, dac_code} == it, "R8 outputs at strobe", {2'b0, pwr_mode, dac_code}, {2'b0, it});
            end
         end
         prev_stb <= upd_stb;
      end
   end

   task automatic send(input logic [31:0] bits, input int n, input string tag);
      cs_n = 1'b0;
      #30;
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b1;
         sdin = bits[i];
         #20;
         sclk = 1'b0;
         #20;
      end
      #30;
      cs_n = 1'b1;
      if (n == 16) begin
         if (bits[15:12] == 4'h0) begin
            exp_code = bits[11:0];
            exp_mode = 2'b00;
            sb_q.push_back({exp_mode, exp_code});
         end else if (bits[15:12] == 4'hF) begin
            exp_mode = bits[1:0];
            sb_q.push_back({exp_mode, exp_code});
         end
      end
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(sb_q.size() == 0, {tag, " strobe seen"}, 16'(sb_q.size()), 16'd0);
      chk(dac_code == exp_code, {tag, " code"}, {4'h0, dac_code}, {4'h0, exp_code});
      chk(pwr_mode == exp_mode, {tag, " mode"}, {14'h0, pwr_mode}, {14'h0, exp_mode});
      #100;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dac_code == 12'h0, "R1 reset code", {4'h0, dac_code}, 16'h0);
      chk(pwr_mode == 2'b00, "R1 reset mode", {14'h0, pwr_mode}, 16'h0);
      chk(upd_stb == 1'b0, "R1 reset strobe", {15'h0, upd_stb}, 16'h0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);

      send(32'h0A5C, 16, "R2 load a5c");
      send(32'h0FFF, 16, "R2 load fff");
      send(32'h0001, 16, "R2 load 001");
      send(32'h0A5C, 16, "R2 load again");
      send(32'hF3FD, 16, "R3 float with junk");
      send(32'hF002, 16, "R3 1k");
      send(32'hFAAB, 16, "R3 100k");
      send(32'hF000, 16, "R4 wake restores");
      send(32'hF002, 16, "R5 enter 1k");
      send(32'h0123, 16, "R5 load wakes");
      send(32'hF001, 16, "R5 enter float");
      send(32'h0123, 16, "R5 same code wakes");
      send(32'h5777, 16, "R6 cmd 0101");
      send(32'h8003, 16, "R6 cmd 1000");
      send(32'h0EEE >> 1, 15, "R7 short frame");
      send(32'h1F003, 17, "R7 long frame");
      send(32'h00001, 17, "R7 long load");

      // serial clock activity with select high
      for (int k = 0; k < 20; k++) begin
         sdin = k[0];
         sclk = 1'b1;
         #20;
         sclk = 1'b0;
         #20;
      end
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(dac_code == exp_code, "R9 code after idle clocks", {4'h0, dac_code}, {4'h0, exp_code});
      chk(pwr_mode == exp_mode, "R9 mode after idle clocks", {14'h0, pwr_mode}, {14'h0, exp_mode});
      send(32'h0456, 16, "R9 clean frame after idle clocks");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule